// File: doc/BRIEF.md
# Scan Chain Integrity Tester

This unit verifies that a scan chain shifts correctly before any test vectors are loaded through it. A single-cycle `start` pulse begins a run. For the whole run the unit holds the chain's test control low, which selects scan mode. It feeds the chain's serial input with the repeating bit sequence 0,0,1,1. Over the run every flip-flop in the chain therefore sees a hold at 0, a rise, a hold at 1 and a fall.

A run lasts `CHAIN_LEN + 4` clock cycles. A healthy chain of `CHAIN_LEN` stages returns each input bit exactly `CHAIN_LEN` cycles after it went in. From cycle `CHAIN_LEN` onward, the unit compares the bit observed at the chain's serial output with the bit it drove that many cycles earlier. When the run ends, it raises `done`. It also reports whether any mismatch occurred and the index of the cycle where the first mismatch was seen.

The sequence comes from a small cycle counter, so the unit stores no pattern. Another `start` pulse clears the result and repeats the test.

Top module: `scan_chain_checker`

## Requirements
- R1: A `start` sampled high on a clock edge clears `done`, `fail` and `err_idx` and begins a run, with `busy` high from the next cycle. While `busy` is high, `test_ctrl` is 0 (scan mode). While idle, `test_ctrl` is 1 and `scan_in` is 0.
- R2: In run cycle k (k = 0 for the first cycle with `busy` high), `scan_in` equals bit 1 of k, which gives the sequence 0,0,1,1 repeated.
- R3: A run lasts exactly `CHAIN_LEN + 4` cycles. In the cycle after the last one, `busy` is 0 and `done` is 1. `done` stays 0 throughout the run.
- R4: In run cycle k with k >= `CHAIN_LEN`, the expected `scan_out` is bit 1 of (k - `CHAIN_LEN`). Values of `scan_out` in cycles k < `CHAIN_LEN` have no effect on the result.
- R5: `fail` is set by the first mismatch and stays set until the next `start`. `pass` is high exactly when `done` is 1 and `fail` is 0.
- R6: `err_idx` holds the cycle index k of the first mismatch and does not change on later mismatches. It is 0 when the run had no mismatch.
- R7: After reset, `busy`, `done`, `pass`, `fail`, `err_idx` and `scan_in` are 0 and `test_ctrl` is 1.
- R8: A `start` given after a failed run clears `fail`, and a healthy chain then passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Synchronous pulse that starts or restarts a run |
| scan_out | input | 1 | Serial output of the chain under test |
| test_ctrl | output | 1 | Test control to the chain; 0 selects scan mode |
| scan_in | output | 1 | Serial input driven into the chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Sticky mismatch flag |
| err_idx | output | $clog2(CHAIN_LEN+4) | Run cycle index of the first mismatch |

## Verification
The bench models the chain as a shift register and injects several kinds of fault into it. A fault-free chain must pass. A stuck-at-0 or stuck-at-1 fault, placed at every stage position in turn, must fail at the cycle where the wrong value first reaches the output. A chain one stage too short or one stage too long must fail, which shows the comparison is aligned to the exact delay. Inverting the output only before cycle `CHAIN_LEN` must still pass, which shows early output is ignored. Inverting it only in the last cycle, or in every compared cycle, shows that the first mismatch index is latched and is not overwritten by later mismatches.

// File: rtl/scan_chain_checker.sv
module scan_chain_checker #(
  parameter int CHAIN_LEN = 8,
  localparam int RUN_LEN = CHAIN_LEN + 4,
  localparam int CW = $clog2(RUN_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          scan_out,
  output logic          test_ctrl,
  output logic          scan_in,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [CW-1:0] err_idx
);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
  localparam logic [CW-1:0] LEN  = CW'(CHAIN_LEN);

  logic [CW-1:0] cyc;
  logic [CW-1:0] rel;
  logic          cmp_en;
  logic          mismatch;

  assign rel       = cyc - LEN;
  assign cmp_en    = busy && (cyc >= LEN);
  assign mismatch  = cmp_en && (scan_out != rel[1]);
  assign scan_in   = busy && cyc[1];
  assign test_ctrl = !busy;
  assign pass      = done && !fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cyc     <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      err_idx <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cyc     <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      err_idx <= '0;
    end else if (busy) begin
      if (mismatch && !fail) begin
        fail    <= 1'b1;
        err_idx <= cyc;
      end
      if (cyc == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

module scan_chain_checker_sva #(
  parameter int CHAIN_LEN = 8,
  localparam int CW = $clog2(CHAIN_LEN + 4)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          test_ctrl,
  input logic          scan_in,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [CW-1:0] err_idx
);
  int run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_cnt <= 0;
    else if (start) run_cnt <= 0;
    else if (busy)  run_cnt <= run_cnt + 1;
  end

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !fail && !done && (err_idx == '0));
  assert_scan_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !test_ctrl);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> test_ctrl && !scan_in);
  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == CHAIN_LEN + 4) && done);
  assert_no_done_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);
  assert_pass_meaning_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done && !fail);
  assert_idx_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> $stable(err_idx));
endmodule

bind scan_chain_checker scan_chain_checker_sva #(.CHAIN_LEN(CHAIN_LEN)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .test_ctrl(test_ctrl),
  .scan_in(scan_in), .busy(busy), .done(done), .pass(pass), .fail(fail),
  .err_idx(err_idx)
);

// File: tb/test_scan_chain_checker.sv
module test_scan_chain_checker;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 4);
  localparam int M_NONE = 0, M_SA0 = 1, M_SA1 = 2, M_EARLY = 3, M_LATE = 4, M_ALL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scan_out, test_ctrl, scan_in, busy, done, pass, fail;
  logic [CW-1:0] err_idx;

  int checks = 0;
  int fails = 0;
  int fmode = M_NONE;
  int fpos = 0;
  int flen = N;
  logic flip_now = 1'b0;

  logic [N:0] q = '0;
  logic [N:0] o;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i <= N; i++)
      o[i] = (fmode == M_SA0 && i == fpos) ? 1'b0 :
             (fmode == M_SA1 && i == fpos) ? 1'b1 : q[i];
  end

  always_ff @(posedge clk) begin
    if (!test_ctrl) begin
      q[0] <= scan_in;
      for (int i = 1; i <= N; i++) q[i] <= o[i-1];
    end
  end

  assign scan_out = o[flen-1] ^ flip_now;

  scan_chain_checker #(.CHAIN_LEN(N)) i_scan_chain_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_out(scan_out),
    .test_ctrl(test_ctrl), .scan_in(scan_in), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .err_idx(err_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int mode, input int pos, input int len);
    logic exp_fail;
    int   exp_idx;
    fmode = mode; fpos = pos; flen = len;
    exp_fail = 1'b0; exp_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < N + 4; k++) begin
      flip_now = (mode == M_EARLY && k < N) || (mode == M_LATE && k == N + 3) ||
                 (mode == M_ALL && k >= N);
      #1;
      check("R2 scan_in pattern", int'(scan_in), (k >> 1) & 1);
      check("R1 test_ctrl in run", int'(test_ctrl), 0);
      check("R3 busy in run", int'(busy), 1);
      check("R3 done low in run", int'(done), 0);
      if (k >= N && !exp_fail && int'(scan_out) != (((k - N) >> 1) & 1)) begin
        exp_fail = 1'b1;
        exp_idx = k;
      end
      @(negedge clk);
    end
    flip_now = 1'b0;
    check("R3 done after run", int'(done), 1);
    check("R3 busy after run", int'(busy), 0);
    check("R1 test_ctrl idle", int'(test_ctrl), 1);
    check("R4 R5 fail result", int'(fail), int'(exp_fail));
    check("R5 pass result", int'(pass), int'(!exp_fail));
    check("R6 first mismatch index", int'(err_idx), exp_idx);
    @(negedge clk);
    check("R5 fail sticky while idle", int'(fail), int'(exp_fail));
    check("R6 index held while idle", int'(err_idx), exp_idx);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R7 reset busy", int'(busy), 0);
    check("R7 reset done", int'(done), 0);
    check("R7 reset fail", int'(fail), 0);
    check("R7 reset pass", int'(pass), 0);
    check("R7 reset err_idx", int'(err_idx), 0);
    check("R7 reset scan_in", int'(scan_in), 0);
    check("R7 reset test_ctrl", int'(test_ctrl), 1);
    rst_n = 1'b1;
    @(negedge clk);

    run(M_NONE, 0, N);
    check("R5 healthy chain passes", int'(pass), 1);
    for (int p = 0; p < N; p++) run(M_SA0, p, N);
    for (int p = 0; p < N; p++) run(M_SA1, p, N);
    check("R8 fail before rerun", int'(fail), 1);
    run(M_NONE, 0, N);
    check("R8 rerun clears fail", int'(fail), 0);
    run(M_NONE, 0, N - 1);
    check("R4 short chain fails", int'(fail), 1);
    run(M_NONE, 0, N);
    run(M_NONE, 0, N + 1);
    check("R4 long chain fails", int'(fail), 1);
    run(M_NONE, 0, N);
    run(M_EARLY, 0, N);
    check("R4 early output ignored", int'(pass), 1);
    run(M_LATE, 0, N);
    check("R6 last-cycle mismatch index", int'(err_idx), N + 3);
    run(M_ALL, 0, N);
    check("R6 first of many mismatches", int'(err_idx), N);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule